// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the pin activity of a small controller's shared external bus. One clock is one state, and six states make one machine cycle. An ordinary cycle fetches two program bytes, one per half-cycle. A cycle marked as a data access spends its whole length on a single data read or write, and no program strobe appears in it. The low address byte and the data share one output port. A second port carries the high address byte, or passes through the general-purpose value latched for that port.

A strap input sets how program space is split. When it is high, program addresses below a parameterised internal size are served from on-chip memory, so no program strobe is issued for them. When it is low, every fetch goes to the bus. The caller presents the fetch address and any data request during state 5. They take effect in the machine cycle that begins at the next clock edge.

Top module: `extbus_seq`

## Requirements
- R1: The `phase` output counts 0,1,2,3,4,5 and wraps to 0. The request inputs present during phase 5 are captured at the edge that ends it.
- R2: In a fetch cycle `ale` is high in phases 0 and 3. In a data cycle it is high only in phase 0.
- R3: In a fetch cycle with both halves external, `psenN` is low in phases 1-2 for `fetchAddr` and in phases 4-5 for `fetchAddr`+1 (modulo 2^16). The second byte is always fetched.
- R4: In a data cycle `psenN` stays high for all six phases.
- R5: With `eaStrap`=1, a fetch half whose address is below 0x1000 is internal: no `psenN` pulse, no bus drive, and `hiOut` equals `hiLatch`. With `eaStrap`=0 every half is external.
- R6: A data read drives `rdN` low in phases 1-4. A data write drives `wrN` low in phases 1-4. At most one of `psenN`, `rdN` and `wrN` is low at a time.
- R7: `busOe` is high with `busOut` equal to the low address byte while `ale` is high for an external half or a data cycle. It is low during a read strobe. During a write strobe, `busOe` is high and `busOut` equals `wrData`.
- R8: `hiOut` carries the high address byte for all three phases of an external fetch half, and for the whole of a 16-bit data cycle (`dataWide`=1).
- R9: In an 8-bit data cycle (`dataWide`=0), `hiOut` equals `hiLatch` and only `dataAddr[7:0]` is used.
- R10: While `rstN` is low: `phase`=5, `ale`=0, `psenN`=`rdN`=`wrN`=1, `busOe`=0 and `hiOut`=`hiLatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rstN | input | 1 | Asynchronous reset, active low |
| eaStrap | input | 1 | 1: low program space internal; 0: all fetches external |
| fetchAddr | input | 16 | Program address of the first byte of the cycle |
| dataReq | input | 1 | Next cycle is a data access |
| dataWrite | input | 1 | Data access is a write |
| dataWide | input | 1 | Data address is 16-bit (else 8-bit) |
| dataAddr | input | 16 | Data address |
| wrData | input | 8 | Write data |
| hiLatch | input | 8 | Latched value of the high port |
| ale | output | 1 | Address latch enable |
| psenN | output | 1 | Program read strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| busOut | output | 8 | Multiplexed low address / write data |
| busOe | output | 1 | Drive enable for busOut |
| hiOut | output | 8 | High port value |
| phase | output | 3 | Current state of the machine cycle |

## Verification
Fetch cycles are run with the strap both high and low at the same address. This separates the internal/external decision from the strobe timing. The addresses 0x0FFF and 0xFFFF make the two halves of one cycle fall on opposite sides of the split: the first crosses upward, and the second wraps to zero. Data reads and writes are run with 8-bit and 16-bit addresses. These show apart the strobe chosen, the bus direction and the source of the high port. A long random mix of all of these checks the behaviour from one cycle to the next, against a per-phase model of the outputs.

// File: rtl/extbus_seq_pkg.sv
package extbus_seq_pkg;
  localparam int NUM_STATES = 6;
  localparam int PH_W = 3;

  typedef struct packed {
    logic load;
    logic ale;
    logic psenN;
    logic rdN;
    logic wrN;
    logic busDrive;
    logic busData;
    logic hiAddr;
    logic secondFetch;
    logic useData;
  } strobe_t;
endpackage

// File: rtl/extbus_seq_ctrl.sv
module extbus_seq_ctrl
  import extbus_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            dataReq,
  input  logic            dataWrite,
  input  logic            dataWide,
  input  logic            extNowA,
  input  logic            extNowB,
  output strobe_t         strb,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_STATES - 1);
  localparam logic [PH_W-1:0] HALF = PH_W'(NUM_STATES / 2);

  logic valid, isData, isWrite, isWide, extA, extB;
  logic load, firstHalf, inAle, extCur, dataSpan;

  assign load = (phase == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= LAST;
      valid   <= 1'b0;
      isData  <= 1'b0;
      isWrite <= 1'b0;
      isWide  <= 1'b0;
      extA    <= 1'b0;
      extB    <= 1'b0;
    end else begin
      phase <= load ? '0 : phase + PH_W'(1);
      if (load) begin
        valid   <= 1'b1;
        isData  <= dataReq;
        isWrite <= dataWrite;
        isWide  <= dataWide;
        extA    <= extNowA;
        extB    <= extNowB;
      end
    end
  end

  assign firstHalf = (phase < HALF);
  assign inAle     = (phase == '0) || (phase == HALF);
  assign extCur    = firstHalf ? extA : extB;
  assign dataSpan  = (phase != '0) && (phase != LAST);

  always_comb begin
    strb             = '0;
    strb.load        = load;
    strb.psenN       = 1'b1;
    strb.rdN         = 1'b1;
    strb.wrN         = 1'b1;
    strb.secondFetch = !firstHalf;
    strb.useData     = isData;
    if (valid) begin
      if (isData) begin
        strb.ale      = (phase == '0);
        strb.busDrive = (phase == '0) || (isWrite && dataSpan);
        strb.busData  = isWrite && dataSpan;
        strb.rdN      = !(!isWrite && dataSpan);
        strb.wrN      = !(isWrite && dataSpan);
        strb.hiAddr   = isWide;
      end else begin
        strb.ale      = inAle;
        strb.busDrive = inAle && extCur;
        strb.psenN    = !(extCur && !inAle);
        strb.hiAddr   = extCur;
      end
    end
  end
endmodule

// File: rtl/extbus_seq_dp.sv
module extbus_seq_dp
  import extbus_seq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int INT_SIZE = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              eaStrap,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-DATA_W-1:0] hiLatch,
  output logic              extNowA,
  output logic              extNowB,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-DATA_W-1:0] hiOut
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(INT_SIZE);

  logic [ADDR_W-1:0] fA, dA, fB, fNext, fetchSel;
  logic [DATA_W-1:0] wD;

  assign fNext   = fetchAddr + ADDR_W'(1);
  assign extNowA = !eaStrap || (fetchAddr >= LIMIT);
  assign extNowB = !eaStrap || (fNext >= LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fA <= '0;
      dA <= '0;
      wD <= '0;
    end else if (strb.load) begin
      fA <= fetchAddr;
      dA <= dataAddr;
      wD <= wrData;
    end
  end

  assign fB       = fA + ADDR_W'(1);
  assign fetchSel = strb.secondFetch ? fB : fA;

  always_comb begin
    if (strb.busData)      busOut = wD;
    else if (strb.useData) busOut = dA[DATA_W-1:0];
    else                   busOut = fetchSel[DATA_W-1:0];
  end

  always_comb begin
    if (!strb.hiAddr)      hiOut = hiLatch;
    else if (strb.useData) hiOut = dA[ADDR_W-1 -: HI_W];
    else                   hiOut = fetchSel[ADDR_W-1 -: HI_W];
  end

  assign busOe = strb.busDrive;
  assign ale   = strb.ale;
  assign psenN = strb.psenN;
  assign rdN   = strb.rdN;
  assign wrN   = strb.wrN;
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        eaStrap,
  input  logic [15:0] fetchAddr,
  input  logic        dataReq,
  input  logic        dataWrite,
  input  logic        dataWide,
  input  logic [15:0] dataAddr,
  input  logic [7:0]  wrData,
  input  logic [7:0]  hiLatch,
  output logic        ale,
  output logic        psenN,
  output logic        rdN,
  output logic        wrN,
  output logic [7:0]  busOut,
  output logic        busOe,
  output logic [7:0]  hiOut,
  output logic [2:0]  phase
);
  strobe_t strb;
  logic extNowA, extNowB;

  extbus_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dataReq(dataReq), .dataWrite(dataWrite),
    .dataWide(dataWide), .extNowA(extNowA), .extNowB(extNowB),
    .strb(strb), .phase(phase)
  );

  extbus_seq_dp #(.ADDR_W(16), .DATA_W(8), .INT_SIZE(4096)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .eaStrap(eaStrap),
    .fetchAddr(fetchAddr), .dataAddr(dataAddr), .wrData(wrData),
    .hiLatch(hiLatch), .extNowA(extNowA), .extNowB(extNowB),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .busOut(busOut), .busOe(busOe), .hiOut(hiOut)
  );
endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk
  import extbus_seq_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            ale,
  input logic            psenN,
  input logic            rdN,
  input logic            wrN,
  input logic            busOe,
  input logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_STATES - 1);

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == LAST) |=> (phase == '0));
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phase != LAST) |=> (phase == $past(phase) + PH_W'(1)));
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~psenN, ~rdN, ~wrN}));
  assert_rd_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> (phase == PH_W'(1)));
  assert_read_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busOe);
  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busOe);
  assert_psen_no_ale_R3: assert property (@(posedge clk) disable iff (!rstN)
    !psenN |-> !ale);
endmodule

bind extbus_seq extbus_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .ale(ale), .psenN(psenN), .rdN(rdN),
  .wrN(wrN), .busOe(busOe), .phase(phase)
);

// File: tb/extbus_seq_bench.sv
`timescale 1ns/1ps
module extbus_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eaStrap = 1'b1;
  logic [15:0] fetchAddr = '0;
  logic dataReq = 1'b0, dataWrite = 1'b0, dataWide = 1'b0;
  logic [15:0] dataAddr = '0;
  logic [7:0] wrData = '0, hiLatch = 8'h5A;
  logic ale, psenN, rdN, wrN, busOe;
  logic [7:0] busOut, hiOut;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  extbus_seq u_extbus_seq (
    .clk(clk), .rstN(rstN), .eaStrap(eaStrap), .fetchAddr(fetchAddr),
    .dataReq(dataReq), .dataWrite(dataWrite), .dataWide(dataWide),
    .dataAddr(dataAddr), .wrData(wrData), .hiLatch(hiLatch),
    .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN), .busOut(busOut),
    .busOe(busOe), .hiOut(hiOut), .phase(phase)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isExt(logic [15:0] a, logic strap);
    return !strap || (a >= 16'h1000);
  endfunction

  // request captured for the cycle in progress
  logic cq, cw, cwide, cstrap;
  logic [15:0] caddr, cfetch;
  logic [7:0] cwd;

  task automatic setReq(logic strap, logic [15:0] fa, logic rq, logic rw,
                        logic wide, logic [15:0] da, logic [7:0] wd, logic [7:0] hl);
    eaStrap = strap; fetchAddr = fa; dataReq = rq; dataWrite = rw;
    dataWide = wide; dataAddr = da; wrData = wd; hiLatch = hl;
    cstrap = strap; cfetch = fa; cq = rq; cw = rw; cwide = wide;
    caddr = da; cwd = wd;
  endtask

  task automatic checkPhase(int k);
    logic [15:0] a;
    logic ex, eAle, ePsen, eRd, eWr, eOe, span;
    logic [7:0] eBus, eHi;
    span = (k >= 1 && k <= 4);
    chk("R1 phase", 16'(phase), 16'(k));
    if (cq) begin
      eAle = (k == 0); ePsen = 1'b1;
      eRd = !(!cw && span); eWr = !(cw && span);
      eOe = (k == 0) || (cw && span);
      eBus = (cw && span) ? cwd : caddr[7:0];
      eHi = cwide ? caddr[15:8] : hiLatch;
      chk("R4 psenN in data cycle", 16'(psenN), 16'(ePsen));
      if (cwide) chk("R8 hiOut wide data", 16'(hiOut), 16'(eHi));
      else       chk("R9 hiOut narrow data", 16'(hiOut), 16'(eHi));
    end else begin
      a = (k < 3) ? cfetch : cfetch + 16'd1;
      ex = isExt(a, cstrap);
      eAle = (k == 0) || (k == 3);
      ePsen = !(ex && !eAle);
      eRd = 1'b1; eWr = 1'b1;
      eOe = eAle && ex;
      eBus = a[7:0];
      eHi = ex ? a[15:8] : hiLatch;
      if (ex) begin
        chk("R3 psenN external fetch", 16'(psenN), 16'(ePsen));
        chk("R8 hiOut fetch address", 16'(hiOut), 16'(eHi));
      end else begin
        chk("R5 psenN internal fetch", 16'(psenN), 16'(ePsen));
        chk("R5 hiOut internal fetch", 16'(hiOut), 16'(eHi));
      end
    end
    chk("R2 ale", 16'(ale), 16'(eAle));
    chk("R6 rdN", 16'(rdN), 16'(eRd));
    chk("R6 wrN", 16'(wrN), 16'(eWr));
    chk("R7 busOe", 16'(busOe), 16'(eOe));
    if (eOe) chk("R7 busOut", 16'(busOut), 16'(eBus));
  endtask

  task automatic runCycle(logic strap, logic [15:0] fa, logic rq, logic rw,
                          logic wide, logic [15:0] da, logic [7:0] wd, logic [7:0] hl);
    setReq(strap, fa, rq, rw, wide, da, wd, hl);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      checkPhase(k);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 phase in reset", 16'(phase), 16'd5);
    chk("R10 ale in reset", 16'(ale), 16'd0);
    chk("R10 psenN in reset", 16'(psenN), 16'd1);
    chk("R10 rdN in reset", 16'(rdN), 16'd1);
    chk("R10 wrN in reset", 16'(wrN), 16'd1);
    chk("R10 busOe in reset", 16'(busOe), 16'd0);
    chk("R10 hiOut in reset", 16'(hiOut), 16'(hiLatch));
    rstN = 1'b1;
    // directed cases
    runCycle(1'b1, 16'h0100, 0, 0, 0, 16'h0, 8'h0, 8'h33);      // R5 internal
    runCycle(1'b0, 16'h0100, 0, 0, 0, 16'h0, 8'h0, 8'h33);      // R5 strap low
    runCycle(1'b1, 16'h0FFF, 0, 0, 0, 16'h0, 8'h0, 8'hC1);      // R5 split boundary
    runCycle(1'b1, 16'hFFFF, 0, 0, 0, 16'h0, 8'h0, 8'h7E);      // R3 wrap
    runCycle(1'b1, 16'h2345, 1, 0, 1, 16'hBEEF, 8'h00, 8'h11);  // R6 wide read
    runCycle(1'b1, 16'h2346, 1, 1, 0, 16'hABCD, 8'h96, 8'h22);  // R9 narrow write
    runCycle(1'b0, 16'h0002, 1, 1, 1, 16'h1357, 8'h69, 8'h44);  // R8 wide write
    runCycle(1'b1, 16'h8000, 0, 0, 0, 16'h0, 8'h0, 8'h55);      // R3 external
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [15:0] fa;
      fa = ($urandom % 2) ? 16'($urandom % 16'h2000) : 16'($urandom);
      runCycle(1'($urandom), fa, ($urandom % 3) == 0, 1'($urandom),
               1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom));
    end
    finish();
  end
endmodule